// File: doc/BRIEF.md
# Undervoltage Pad Freeze Guard

This block sits between the digital registers of an 8-pin general-purpose I/O port and the pad cells. In normal operation it passes the programmed direction, output data and pull configuration through to the pads. It also brings each raw pad level into the clock domain through a short synchronizer and then into a readable input register.

While an undervoltage flag from the supply monitor is high, the block cuts every strong output driver and every weak pull resistor. It also freezes the input register at the value it held when the flag rose, so pad activity during the event cannot reach the logic. When the flag falls, the block keeps the pads quiet for one more cycle and then restores the configuration. The input register then follows the synchronized pads again.

The configuration inputs are always accepted. Values written during an event reach the pads only after release. The flag is expected to be synchronous to `clk`.

Top module: `uv_pad_guard`

## Requirements
- R1: With `uv_flag` low in the current and the previous cycle, `pad_oe` equals `cfg_dir` bit for bit, where a 1 in `cfg_dir` marks an output pin.
- R2: In any cycle in which `uv_flag` is high, `pad_oe` is all zeros within that same cycle.
- R3: In any cycle in which `uv_flag` is high, `pad_pu_en` and `pad_pd_en` are both all zeros.
- R4: Outside an event, a pin has a pull enabled only when it is an input (`cfg_dir` bit 0) and its `cfg_pull_en` bit is 1. The pull is upward (`pad_pu_en`) when its `cfg_pull_up` bit is 1 and downward (`pad_pd_en`) when it is 0. Both are never high together, and neither is high on a pin whose `pad_oe` is high.
- R5: Outside an event, a pad level present at a rising edge of `clk` appears on `in_val` after the second rising edge that follows it, which is three register stages.
- R6: At every rising edge where `uv_flag` is high, `in_val` keeps its value, whatever `pad_in` does. The value held is the one present when the flag was first seen.
- R7: At the first rising edge where `uv_flag` is low again, `in_val` resumes loading the synchronized pad value.
- R8: In the cycle right after `uv_flag` falls, all output and pull enables are still zero. They return to their programmed values from the following cycle on.
- R9: Changes to `cfg_dir`, `cfg_pull_en` or `cfg_pull_up` made while `uv_flag` is high have no effect on the pads until the release of R8, and are then applied.
- R10: `pad_out` equals `cfg_dout` at all times.
- R11: A rising edge with `rst` high clears `in_val` and the synchronizer to zero and clears the release hold, independent of `pad_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_flag | input | 1 | Undervoltage indication, synchronous to clk |
| cfg_dir | input | 8 | Per-pin direction, 1 = output |
| cfg_dout | input | 8 | Per-pin output data |
| cfg_pull_en | input | 8 | Per-pin pull resistor enable |
| cfg_pull_up | input | 8 | Per-pin pull select, 1 = up, 0 = down |
| pad_in | input | 8 | Raw pad input levels |
| pad_oe | output | 8 | Pad driver enables |
| pad_out | output | 8 | Pad output data |
| pad_pu_en | output | 8 | Pad pull-up enables |
| pad_pd_en | output | 8 | Pad pull-down enables |
| in_val | output | 8 | Input register value |

## Verification
The hardest case to reach is a pad change that is still inside the synchronizer when the flag rises. The event must freeze the value already in the input register, not the newer level moving through the two stages. The stimulus holds one pad pattern long enough to settle and then presents a different pattern exactly one cycle before raising the flag. It keeps toggling the pads during the event and checks that the settled pattern, not the late one, is held throughout. A one-cycle flag pulse and configuration edits made inside the event then test the one-cycle release hold and the late application of the new settings.

// File: rtl/uv_pad_pkg.sv
package uv_pad_pkg;

    localparam int unsigned PORT_W     = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    typedef logic [PORT_W-1:0] pin_vec_t;

    typedef enum logic {
        GATE_OPEN = 1'b0,
        GATE_SHUT = 1'b1
    } gate_e;

    typedef struct packed {
        pin_vec_t dir;
        pin_vec_t dout;
        pin_vec_t pull_en;
        pin_vec_t pull_up;
    } port_cfg_t;

    typedef struct packed {
        pin_vec_t oe;
        pin_vec_t dout;
        pin_vec_t pu;
        pin_vec_t pd;
    } pad_ctrl_t;

    // Derive pad controls from the programmed settings; block forces all enables off.
    function automatic pad_ctrl_t shape_pads(port_cfg_t cfg, logic block);
        pad_ctrl_t c;
        pin_vec_t  keep;
        pin_vec_t  pull_ok;
        keep    = block ? '0 : '1;
        pull_ok = cfg.pull_en & ~cfg.dir & keep;
        c.oe    = cfg.dir & keep;
        c.dout  = cfg.dout;
        c.pu    = pull_ok & cfg.pull_up;
        c.pd    = pull_ok & ~cfg.pull_up;
        return c;
    endfunction

endpackage

// File: rtl/uv_pad_sync.sv
module uv_pad_sync #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [WIDTH-1:0] stage_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < DEPTH; s++) begin
                stage_q[s] <= '0;
            end
        end else begin
            stage_q[0] <= raw;
            for (int s = 1; s < DEPTH; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign synced = stage_q[LAST];

endmodule

// File: rtl/uv_in_hold.sv
module uv_in_hold #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             freeze,
    input  logic [WIDTH-1:0] synced,
    output logic [WIDTH-1:0] held
);

    // One enable flop per pin, so the hold maps onto plain enable registers.
    for (genvar p = 0; p < WIDTH; p++) begin : g_pin
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                bit_q <= 1'b0;
            end else if (!freeze) begin
                bit_q <= synced[p];
            end
        end
        assign held[p] = bit_q;
    end

endmodule

// File: rtl/uv_drive_gate.sv
module uv_drive_gate
    import uv_pad_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      uv,
    input  port_cfg_t cfg,
    output pad_ctrl_t ctrl
);

    gate_e gate_q;
    logic  block;

    always_ff @(posedge clk) begin
        if (rst) begin
            gate_q <= GATE_OPEN;
        end else begin
            gate_q <= uv ? GATE_SHUT : GATE_OPEN;
        end
    end

    // Immediate shut on the live flag; release waits one edge.
    assign block = uv | (gate_q == GATE_SHUT);

    always_comb begin
        ctrl = shape_pads(cfg, block);
    end

endmodule

// File: rtl/uv_pad_guard.sv
module uv_pad_guard
    import uv_pad_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              uv_flag,
    input  logic [PORT_W-1:0] cfg_dir,
    input  logic [PORT_W-1:0] cfg_dout,
    input  logic [PORT_W-1:0] cfg_pull_en,
    input  logic [PORT_W-1:0] cfg_pull_up,
    input  logic [PORT_W-1:0] pad_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out,
    output logic [PORT_W-1:0] pad_pu_en,
    output logic [PORT_W-1:0] pad_pd_en,
    output logic [PORT_W-1:0] in_val
);

    port_cfg_t cfg;
    pad_ctrl_t ctrl;
    pin_vec_t  pad_sync;

    assign cfg.dir     = cfg_dir;
    assign cfg.dout    = cfg_dout;
    assign cfg.pull_en = cfg_pull_en;
    assign cfg.pull_up = cfg_pull_up;

    uv_pad_sync #(
        .WIDTH (PORT_W),
        .DEPTH (SYNC_DEPTH)
    ) sync_i (
        .clk    (clk),
        .rst    (rst),
        .raw    (pad_in),
        .synced (pad_sync)
    );

    uv_in_hold #(
        .WIDTH (PORT_W)
    ) hold_i (
        .clk    (clk),
        .rst    (rst),
        .freeze (uv_flag),
        .synced (pad_sync),
        .held   (in_val)
    );

    uv_drive_gate gate_i (
        .clk  (clk),
        .rst  (rst),
        .uv   (uv_flag),
        .cfg  (cfg),
        .ctrl (ctrl)
    );

    assign pad_oe    = ctrl.oe;
    assign pad_out   = ctrl.dout;
    assign pad_pu_en = ctrl.pu;
    assign pad_pd_en = ctrl.pd;

endmodule

// File: rtl/uv_pad_guard_chk.sv
module uv_pad_guard_chk
    import uv_pad_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              uv_flag,
    input logic [PORT_W-1:0] pad_oe,
    input logic [PORT_W-1:0] pad_pu_en,
    input logic [PORT_W-1:0] pad_pd_en,
    input logic [PORT_W-1:0] in_val
);

    // R2
    uv_drive_off_chk: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> (pad_oe == '0));

    // R3
    uv_pull_off_chk: assert property (@(posedge clk) disable iff (rst)
        uv_flag |-> ((pad_pu_en | pad_pd_en) == '0));

    // R4
    pull_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu_en & pad_pd_en) == '0) && (((pad_pu_en | pad_pd_en) & pad_oe) == '0));

    // R6
    in_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        uv_flag |=> $stable(in_val));

    // R8
    release_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(uv_flag) |-> ((pad_oe | pad_pu_en | pad_pd_en) == '0));

    // R11
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (in_val == '0));

endmodule

bind uv_pad_guard uv_pad_guard_chk chk_i (
    .clk       (clk),
    .rst       (rst),
    .uv_flag   (uv_flag),
    .pad_oe    (pad_oe),
    .pad_pu_en (pad_pu_en),
    .pad_pd_en (pad_pd_en),
    .in_val    (in_val)
);

// File: tb/uv_pad_guard_tb_top.sv
module uv_pad_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst;
    logic       uv_flag;
    logic [7:0] cfg_dir, cfg_dout, cfg_pull_en, cfg_pull_up, pad_in;
    logic [7:0] pad_oe, pad_out, pad_pu_en, pad_pd_en, in_val;

    always #(CLK_PERIOD/2) clk = ~clk;

    uv_pad_guard dut_i (
        .clk         (clk),
        .rst         (rst),
        .uv_flag     (uv_flag),
        .cfg_dir     (cfg_dir),
        .cfg_dout    (cfg_dout),
        .cfg_pull_en (cfg_pull_en),
        .cfg_pull_up (cfg_pull_up),
        .pad_in      (pad_in),
        .pad_oe      (pad_oe),
        .pad_out     (pad_out),
        .pad_pu_en   (pad_pu_en),
        .pad_pd_en   (pad_pd_en),
        .in_val      (in_val)
    );

    typedef struct {
        logic [7:0] oe;
        logic [7:0] dout;
        logic [7:0] pu;
        logic [7:0] pd;
        logic [7:0] inv;
        string      tag;
    } exp_item_t;

    exp_item_t  sb_q[$];
    int         n_vec  = 0;
    int         n_fail = 0;
    bit         done   = 1'b0;

    // Bench-side history for the expected input register.
    logic [7:0] h1 = '0, h2 = '0, h3 = '0, exp_in = '0;
    logic       uv_prev = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    function automatic logic [7:0] next_rand();
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
    endfunction

    task automatic drive(input logic u, input logic [7:0] dir, input logic [7:0] dout,
                         input logic [7:0] pen, input logic [7:0] pup,
                         input logic [7:0] pad, input string tag);
        exp_item_t e;
        logic      shut;
        @(negedge clk);
        rst = 1'b0; uv_flag = u; cfg_dir = dir; cfg_dout = dout;
        cfg_pull_en = pen; cfg_pull_up = pup; pad_in = pad;
        shut   = u | uv_prev;
        exp_in = uv_prev ? exp_in : h3;
        e.oe   = shut ? 8'h00 : dir;
        e.dout = dout;
        e.pu   = shut ? 8'h00 : (pen & ~dir & pup);
        e.pd   = shut ? 8'h00 : (pen & ~dir & ~pup);
        e.inv  = exp_in;
        e.tag  = tag;
        sb_q.push_back(e);
        h3 = h2; h2 = h1; h1 = pad; uv_prev = u;
    endtask

    // Monitor: samples one time unit before each rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #(CLK_PERIOD/2 - 1);
            if (sb_q.size() > 0) begin
                exp_item_t e;
                e = sb_q.pop_front();
                n_vec++;
                if (pad_oe !== e.oe || pad_out !== e.dout || pad_pu_en !== e.pu ||
                    pad_pd_en !== e.pd || in_val !== e.inv) begin
                    n_fail++;
                    $display("FAIL %s: oe=%h/%h out=%h/%h pu=%h/%h pd=%h/%h in=%h/%h (actual/expected)",
                             e.tag, pad_oe, e.oe, pad_out, e.dout, pad_pu_en, e.pu,
                             pad_pd_en, e.pd, in_val, e.inv);
                end
            end
        end
    end

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; uv_flag = 1'b0; cfg_dir = '0; cfg_dout = 8'h3C;
        cfg_pull_en = '0; cfg_pull_up = '0; pad_in = 8'hFF;
        repeat (3) @(negedge clk);
        #(CLK_PERIOD/2 - 1);
        // R11: register stays cleared under reset although pads are high
        n_vec++;
        if (in_val !== 8'h00 || pad_oe !== 8'h00) begin
            n_fail++;
            $display("FAIL R11: in=%h oe=%h expected in=00 oe=00", in_val, pad_oe);
        end

        // R1 R4 R5 R10: normal operation with varied patterns
        for (int i = 0; i < 16; i++) begin
            drive(1'b0, next_rand(), next_rand(), next_rand(), next_rand(), next_rand(), "R1/R4/R5/R10");
        end
        // R4: all pins inputs, mixed pull selection
        drive(1'b0, 8'h00, 8'h00, 8'hFF, 8'h0F, 8'h5A, "R4");
        drive(1'b0, 8'hF0, 8'h00, 8'hFF, 8'h33, 8'h5A, "R4");

        // Settle a known pad value, then change it one cycle before the event
        repeat (4) drive(1'b0, 8'hC3, 8'hA5, 8'h3C, 8'h14, 8'hAA, "R5");
        drive(1'b0, 8'hC3, 8'hA5, 8'h3C, 8'h14, 8'h55, "R6");
        // R2 R3 R6: event with pads toggling
        for (int i = 0; i < 6; i++) begin
            drive(1'b1, 8'hC3, 8'hA5, 8'h3C, 8'h14, next_rand(), "R2/R3/R6");
        end
        // R9: configuration edited inside the event
        for (int i = 0; i < 3; i++) begin
            drive(1'b1, 8'h0F, 8'h99, 8'hF0, 8'hA0, 8'h81, "R9");
        end
        // R8: first cycle after the fall still quiet, then R7/R9 resume
        drive(1'b0, 8'h0F, 8'h99, 8'hF0, 8'hA0, 8'h81, "R8");
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 8'h0F, 8'h99, 8'hF0, 8'hA0, 8'h7E, "R7/R8/R9");
        end

        // Single-cycle event
        drive(1'b0, 8'h81, 8'h18, 8'h7E, 8'h66, 8'h24, "R1");
        drive(1'b1, 8'h81, 8'h18, 8'h7E, 8'h66, 8'hDB, "R2/R3/R6");
        drive(1'b0, 8'h81, 8'h18, 8'h7E, 8'h66, 8'hDB, "R8");
        for (int i = 0; i < 5; i++) begin
            drive(1'b0, 8'h81, next_rand(), 8'h7E, 8'h66, 8'hDB, "R7/R10");
        end

        // Back-to-back events separated by one clear cycle
        drive(1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h11, "R2");
        drive(1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h22, "R8");
        drive(1'b1, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h33, "R2/R6");
        drive(1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h44, "R8");
        for (int i = 0; i < 4; i++) begin
            drive(1'b0, 8'hFF, 8'h00, 8'h00, 8'h00, 8'h44, "R1/R7");
        end

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule